// File: doc/BRIEF.md
# Paged Access Protection Checker

This block sits beside a paging unit and judges one mapped bus cycle at a time. The paging logic supplies the virtual address, the kind of cycle, operand phase, execution mode, whether the instruction stream is currently running from a private page, the instruction word being fetched, and the already resolved 16-bit page map entry. In the same cycle the checker forms the 18-bit physical address, raises a violation strobe and reports a single violation code.

A registered fault status word records the operand phase, mode and fault kind of every checked cycle. When a violation is seen, the status freezes so that software can later inspect what went wrong. It stays frozen until a clear strobe releases it. The code-isolation rule lets public code enter a private page only through a dedicated entry instruction: a branch to the next word.

Top module: `pgprot_check`

## Requirements
- R1: The physical address is the page map entry's low 9 bits (physical page) placed above the low 9 bits (byte offset) of the 16-bit virtual address, giving an 18-bit address. It is combinational.
- R2: A valid cycle whose entry has bit 15 (Resident) clear reports code 2 (residency).
- R3: A valid cycle with `cyc_kind` 2'b10 (write) to an entry whose bit 13 (write enable) is clear reports code 5 (write). `cyc_kind` encodes 2'b00 fetch, 2'b01 read, 2'b10 write; 2'b11 counts as a read.
- R4: A valid cycle at an odd virtual address reports code 1 (address) when it is a fetch or `cyc_byte` is 0 (word access). An odd byte read or write is not an address fault.
- R5: When `prev_private` is 0 (the running code is public) and the entry's bit 14 (Public) is clear, a read or write reports code 3 (privacy).
- R6: Under the same public-to-private condition, a fetch reports code 4 (instruction) unless `fetch_word` equals octal 000401 (branch to next word). With that word the fetch is legal.
- R7: When several faults apply, exactly one code is given, in priority order: address (1), residency (2), privacy (3), instruction (4), write (5). Code 0 means no violation. `viol` is 1 exactly when the code is nonzero, and never when `cyc_valid` is 0.
- R8: While unfrozen, each valid cycle loads `fault_stat` at the next clock edge. Bit 2 takes `cyc_src`, bit 3 takes `cyc_dst`, bit 4 takes `user_mode`, and at most one violation bit is set: 11 instruction, 12 address, 13 write, 14 privacy, 15 residency. All other bits are 0. Reset clears `fault_stat`.
- R9: Once any of bits 15..11 is set, `fault_stat` is frozen. Later cycles, including further violations, leave it unchanged until `stat_clr` is 1.
- R10: `stat_clr` at a clock edge clears `fault_stat`. If a valid cycle is present in that same cycle, that cycle is captured instead, as if the status were unfrozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_valid | input | 1 | A mapped cycle is presented |
| cyc_vaddr | input | 16 | Virtual address |
| cyc_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 read |
| cyc_byte | input | 1 | Byte access (0 = word) |
| cyc_src | input | 1 | Cycle belongs to source operand phase |
| cyc_dst | input | 1 | Cycle belongs to destination operand phase |
| user_mode | input | 1 | 1 = User, 0 = Exec |
| prev_private | input | 1 | Previous instruction fetch came from a private page |
| fetch_word | input | 16 | Instruction word returned for a fetch |
| pme | input | 16 | Resolved page map entry |
| stat_clr | input | 1 | Software clear of the frozen status |
| paddr | output | 18 | Physical address |
| viol | output | 1 | Violation strobe |
| viol_code | output | 3 | Violation code, 0 = none |
| fault_stat | output | 16 | Registered fault status |

## Verification
`paddr`, `viol` and `viol_code` are combinational, so they are due in the same cycle as the stimulus. The bench drives inputs at the falling edge and compares these outputs against its model shortly before the next rising edge. `fault_stat` is due one rising edge after the cycle that loads or clears it. The bench therefore advances its model status only after each rising edge and compares it in the following cycle's sample slot. Directed cases cover each fault alone, each pairwise priority, the entry word, odd byte accesses and clear-versus-capture. A long run of random cycles then exercises freeze and release.

// File: rtl/pgprot_pkg.sv
package pgprot_pkg;

  typedef enum logic [1:0] {
    CK_FETCH = 2'b00,
    CK_READ  = 2'b01,
    CK_WRITE = 2'b10,
    CK_ALT   = 2'b11
  } cyc_kind_e;

  typedef enum logic [2:0] {
    VC_NONE  = 3'd0,
    VC_ADDR  = 3'd1,
    VC_RES   = 3'd2,
    VC_PRIV  = 3'd3,
    VC_INSN  = 3'd4,
    VC_WRITE = 3'd5
  } viol_code_e;

  localparam int NUM_CODES   = 6;
  localparam int PME_WE_BIT  = 13;
  localparam int PME_PUB_BIT = 14;
  localparam int PME_RES_BIT = 15;
  localparam int ST_SRC_BIT  = 2;
  localparam int ST_DST_BIT  = 3;
  localparam int ST_MODE_BIT = 4;

  // status bit that records a given violation code; -1 for none
  function automatic int code_stat_bit(input logic [2:0] c);
    case (c)
      VC_INSN:  return 11;
      VC_ADDR:  return 12;
      VC_WRITE: return 13;
      VC_PRIV:  return 14;
      VC_RES:   return 15;
      default:  return -1;
    endcase
  endfunction

endpackage

// File: rtl/pgprot_xlate.sv
module pgprot_xlate #(
  parameter int VA_W  = 16,
  parameter int OFF_W = 9,
  parameter int PPN_W = 9,
  parameter int PME_W = 16,
  localparam int PA_W = PPN_W + OFF_W
) (
  input  logic [VA_W-1:0]  vaddr,
  input  logic [PME_W-1:0] pme,
  output logic [PA_W-1:0]  paddr,
  output logic             resident,
  output logic             wr_en,
  output logic             is_public,
  output logic             odd_addr
);
  import pgprot_pkg::*;

  function automatic logic [PA_W-1:0] join_addr(input logic [PPN_W-1:0] ppn,
                                                 input logic [OFF_W-1:0] off);
    return {ppn, off};
  endfunction

  assign paddr     = join_addr(pme[PPN_W-1:0], vaddr[OFF_W-1:0]);
  assign resident  = pme[PME_RES_BIT];
  assign wr_en     = pme[PME_WE_BIT];
  assign is_public = pme[PME_PUB_BIT];
  assign odd_addr  = vaddr[0];

  logic unused_hi;
  assign unused_hi = ^{vaddr[VA_W-1:OFF_W], pme[PME_WE_BIT-1:PPN_W]};
endmodule

// File: rtl/pgprot_rules.sv
module pgprot_rules #(
  parameter logic [15:0] ENTRY_OP = 16'o000401,
  parameter int          FW_W     = 16
) (
  input  logic            valid,
  input  logic [1:0]      kind,
  input  logic            byte_acc,
  input  logic            odd_addr,
  input  logic            resident,
  input  logic            wr_en,
  input  logic            is_public,
  input  logic            prev_private,
  input  logic [FW_W-1:0] fetch_word,
  output logic [2:0]      code,
  output logic            hit,
  output logic            pub_to_priv
);
  import pgprot_pkg::*;

  logic is_fetch, is_write;
  logic [NUM_CODES-1:1] cond;

  assign is_fetch    = (cyc_kind_e'(kind) == CK_FETCH);
  assign is_write    = (cyc_kind_e'(kind) == CK_WRITE);
  assign pub_to_priv = !is_public && !prev_private;

  always_comb begin
    cond           = '0;
    cond[VC_ADDR]  = valid && odd_addr && (is_fetch || !byte_acc);
    cond[VC_RES]   = valid && !resident;
    cond[VC_PRIV]  = valid && pub_to_priv && !is_fetch;
    cond[VC_INSN]  = valid && pub_to_priv && is_fetch && (fetch_word != ENTRY_OP);
    cond[VC_WRITE] = valid && is_write && !wr_en;
  end

  // lowest code number has highest priority
  always_comb begin
    code = VC_NONE;
    for (int i = NUM_CODES - 1; i >= 1; i--) begin
      if (cond[i]) code = 3'(i);
    end
  end

  assign hit = |cond;
endmodule

// File: rtl/pgprot_status.sv
module pgprot_status #(
  parameter int ST_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid,
  input  logic [2:0]      code,
  input  logic            src,
  input  logic            dst,
  input  logic            mode,
  input  logic            clr,
  output logic [ST_W-1:0] stat,
  output logic            frozen,
  output logic            capture
);
  import pgprot_pkg::*;

  logic [ST_W-1:0] snap;

  assign frozen  = |stat[ST_W-1:11];
  assign capture = valid && (!frozen || clr);

  for (genvar g = 0; g < ST_W; g++) begin : g_snap
    if (g == ST_SRC_BIT) begin : g_src
      assign snap[g] = src;
    end else if (g == ST_DST_BIT) begin : g_dst
      assign snap[g] = dst;
    end else if (g == ST_MODE_BIT) begin : g_mode
      assign snap[g] = mode;
    end else begin : g_kind
      assign snap[g] = (code_stat_bit(code) == g);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat <= '0;
    else if (capture) stat <= snap;
    else if (clr)     stat <= '0;
  end
endmodule

// File: rtl/pgprot_check.sv
module pgprot_check #(
  parameter int          VA_W     = 16,
  parameter int          OFF_W    = 9,
  parameter int          PPN_W    = 9,
  parameter int          PME_W    = 16,
  parameter int          ST_W     = 16,
  parameter logic [15:0] ENTRY_OP = 16'o000401,
  localparam int         PA_W     = PPN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_valid,
  input  logic [VA_W-1:0]   cyc_vaddr,
  input  logic [1:0]        cyc_kind,
  input  logic              cyc_byte,
  input  logic              cyc_src,
  input  logic              cyc_dst,
  input  logic              user_mode,
  input  logic              prev_private,
  input  logic [15:0]       fetch_word,
  input  logic [PME_W-1:0]  pme,
  input  logic              stat_clr,
  output logic [PA_W-1:0]   paddr,
  output logic              viol,
  output logic [2:0]        viol_code,
  output logic [ST_W-1:0]   fault_stat
);
  logic resident, wr_en, is_public, odd_addr;
  logic pub_to_priv, rule_hit, frozen, capture;

  pgprot_xlate #(.VA_W(VA_W), .OFF_W(OFF_W), .PPN_W(PPN_W), .PME_W(PME_W)) u_xlate (
    .vaddr(cyc_vaddr), .pme(pme), .paddr(paddr), .resident(resident),
    .wr_en(wr_en), .is_public(is_public), .odd_addr(odd_addr)
  );

  pgprot_rules #(.ENTRY_OP(ENTRY_OP), .FW_W(16)) u_rules (
    .valid(cyc_valid), .kind(cyc_kind), .byte_acc(cyc_byte), .odd_addr(odd_addr),
    .resident(resident), .wr_en(wr_en), .is_public(is_public),
    .prev_private(prev_private), .fetch_word(fetch_word),
    .code(viol_code), .hit(rule_hit), .pub_to_priv(pub_to_priv)
  );

  assign viol = rule_hit;

  pgprot_status #(.ST_W(ST_W)) u_status (
    .clk(clk), .rst_n(rst_n), .valid(cyc_valid), .code(viol_code),
    .src(cyc_src), .dst(cyc_dst), .mode(user_mode), .clr(stat_clr),
    .stat(fault_stat), .frozen(frozen), .capture(capture)
  );
endmodule

// File: rtl/pgprot_check_sva.sv
module pgprot_check_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        cyc_valid,
  input logic [1:0]  cyc_kind,
  input logic [15:0] pme,
  input logic        stat_clr,
  input logic        viol,
  input logic [2:0]  viol_code,
  input logic [15:0] fault_stat,
  input logic        frozen,
  input logic        capture,
  input logic        pub_to_priv
);
  // R7
  strobe_needs_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> cyc_valid);
  // R7
  strobe_matches_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol == (viol_code != 3'd0));
  // R2
  nonresident_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !pme[15]) |-> viol);
  // R3
  readonly_write_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_kind == 2'b10 && !pme[13]) |-> viol);
  // R5
  public_data_into_private_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && pub_to_priv && cyc_kind != 2'b00) |-> viol);
  // R8
  single_kind_recorded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fault_stat[15:11]));
  // R9
  frozen_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !stat_clr) |=> $stable(fault_stat));
  // R10
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !cyc_valid) |=> (fault_stat == 16'd0));
  // R8
  capture_violation_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && viol) |=> frozen);
endmodule

bind pgprot_check pgprot_check_sva u_sva (
  .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_kind(cyc_kind), .pme(pme),
  .stat_clr(stat_clr), .viol(viol), .viol_code(viol_code), .fault_stat(fault_stat),
  .frozen(frozen), .capture(capture), .pub_to_priv(pub_to_priv)
);

// File: tb/pgprot_check_test.sv
`timescale 1ns/1ps
module pgprot_check_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cyc_valid = 0;
  logic [15:0] cyc_vaddr = 0;
  logic [1:0]  cyc_kind = 0;
  logic        cyc_byte = 0, cyc_src = 0, cyc_dst = 0, user_mode = 0;
  logic        prev_private = 0, stat_clr = 0;
  logic [15:0] fetch_word = 0, pme = 0;
  logic [17:0] paddr;
  logic        viol;
  logic [2:0]  viol_code;
  logic [15:0] fault_stat;

  int checks = 0, errors = 0;
  logic [15:0] m_stat = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pgprot_check uut (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_vaddr(cyc_vaddr),
    .cyc_kind(cyc_kind), .cyc_byte(cyc_byte), .cyc_src(cyc_src), .cyc_dst(cyc_dst),
    .user_mode(user_mode), .prev_private(prev_private), .fetch_word(fetch_word),
    .pme(pme), .stat_clr(stat_clr), .paddr(paddr), .viol(viol),
    .viol_code(viol_code), .fault_stat(fault_stat)
  );

  // reference: fault kind as an integer, first matching rule in priority order
  function automatic int ref_code();
    bit fetch, wr, into_priv;
    if (!cyc_valid) return 0;
    fetch = (cyc_kind == 2'b00);
    wr = (cyc_kind == 2'b10);
    into_priv = (pme[14] == 1'b0) && (prev_private == 1'b0);
    if (cyc_vaddr % 2 == 1 && (fetch || !cyc_byte)) return 1;     // R4
    if (pme[15] == 1'b0) return 2;                                  // R2
    if (into_priv && !fetch) return 3;                              // R5
    if (into_priv && fetch && fetch_word != 16'd257) return 4;      // R6 (octal 401 = 257)
    if (wr && pme[13] == 1'b0) return 5;                            // R3
    return 0;
  endfunction

  function automatic int status_bit_for(int c);
    int tbl[6] = '{-1, 12, 15, 14, 11, 13};
    return tbl[c];
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // compare outputs before the rising edge, then advance the model
  task automatic sample_and_step(string tag);
    int c, b;
    logic [15:0] nxt;
    c = ref_code();
    check({tag, " R1 paddr"}, paddr, (longint'(pme % 512) * 512) + (cyc_vaddr % 512));
    check({tag, " R7 code"}, viol_code, c);
    check({tag, " R7 strobe"}, viol, (c != 0));
    check({tag, " R8 status"}, fault_stat, m_stat);
    if (cyc_valid && (m_stat[15:11] == 0 || stat_clr)) begin
      nxt = 0;
      nxt[2] = cyc_src; nxt[3] = cyc_dst; nxt[4] = user_mode;
      b = status_bit_for(c);
      if (b >= 0) nxt[b] = 1'b1;
      m_stat = nxt;
    end else if (stat_clr) begin
      m_stat = 0;
    end
    @(posedge clk);
  endtask

  task automatic drive(bit v, logic [15:0] va, logic [1:0] k, bit byt, logic [15:0] e,
                       bit pp, logic [15:0] fw, bit clr, bit s, bit d, bit um, string tag);
    @(negedge clk);
    cyc_valid = v; cyc_vaddr = va; cyc_kind = k; cyc_byte = byt; pme = e;
    prev_private = pp; fetch_word = fw; stat_clr = clr; cyc_src = s; cyc_dst = d; user_mode = um;
    #2;
    sample_and_step(tag);
  endtask

  localparam logic [15:0] OK_PME = 16'hE000 | 16'd300;   // resident, public, writable

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset status", fault_stat, 0);
    rst_n = 1;
    // R1 clean read, translated address
    drive(1, 16'h1234, 2'b01, 0, OK_PME, 0, 0, 0, 1, 0, 1, "R1 clean");
    drive(1, 16'hFFFE, 2'b10, 0, 16'hE000 | 16'd495, 0, 0, 0, 0, 1, 0, "R1 top page");
    // R4 odd word read -> address; odd byte write fine
    drive(1, 16'h0201, 2'b01, 0, OK_PME, 0, 0, 0, 1, 0, 0, "R4 odd word");
    drive(1, 16'h0203, 2'b10, 1, OK_PME, 0, 0, 1, 0, 0, 0, "R10 clear+capture");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4 odd byte ok");
    // R2 non-resident beats write
    drive(1, 16'h0400, 2'b10, 0, 16'h4000, 0, 0, 0, 0, 1, 1, "R2 residency");
    // R9 frozen: new fault ignored
    drive(1, 16'h0401, 2'b01, 0, 16'h0000, 0, 0, 0, 1, 1, 1, "R9 frozen");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 still frozen");
    drive(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R10 clear");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 cleared");
    // R5 public data read into private page
    drive(1, 16'h0800, 2'b01, 0, 16'hA000, 0, 0, 1, 1, 0, 1, "R5 privacy");
    drive(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R10 release");
    // R6 fetch into private with entry word ok, with other word fault
    drive(1, 16'h0800, 2'b00, 0, 16'hA000, 0, 16'o000401, 0, 0, 0, 1, "R6 entry ok");
    drive(1, 16'h0802, 2'b00, 0, 16'hA000, 0, 16'o000402, 0, 0, 0, 1, "R6 bad entry");
    drive(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R10 release");
    // R6 private code fetch in private page needs no entry word
    drive(1, 16'h0804, 2'b00, 0, 16'hA000, 1, 16'h1234, 0, 0, 0, 0, "R6 private caller");
    // R3 write to read-only page
    drive(1, 16'h0C00, 2'b10, 0, 16'hC000, 0, 0, 0, 0, 1, 0, "R3 write");
    drive(1, 16'h0C00, 2'b01, 0, 16'hC000, 0, 0, 1, 0, 0, 0, "R3 read ok after clear");
    // R7 priority: privacy over write, odd fetch over all
    drive(1, 16'h0C00, 2'b10, 0, 16'h8000, 0, 0, 1, 0, 1, 0, "R7 priv>write");
    drive(1, 16'h0C01, 2'b00, 1, 16'h0000, 0, 0, 1, 0, 0, 0, "R7 addr first");
    drive(1, 16'h0C00, 2'b11, 0, 16'h8000, 0, 0, 1, 0, 0, 0, "R3 kind 11 as read");
    drive(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R10 release");
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] e, fw;
      e = 16'($urandom);
      if ($urandom_range(0, 3) != 0) e[15] = 1'b1;
      fw = ($urandom_range(0, 1) != 0) ? 16'o000401 : 16'($urandom);
      drive($urandom_range(0, 4) != 0, 16'($urandom), 2'($urandom_range(0, 3)),
            1'($urandom), e, 1'($urandom), fw, $urandom_range(0, 7) == 0,
            1'($urandom), 1'($urandom), 1'($urandom), "R9 random");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule